// File: doc/BRIEF.md
# Watchdog Toggle Timer Channel

This block is a single timer channel that runs in a watchdog-toggle mode. Software programs it through a small register port. The port holds a reload value, a compare value and a control/status word, and it can read back the live count. Once the channel is enabled, it counts up from the reload value on every timer tick. The tick is either the system clock divided by two or a pulse from an external prescaler. A match against the compare value raises a compare flag. Wrapping past all ones raises an overflow flag. Each flag can raise its own maskable interrupt request.

The channel drives an output pin, together with an output-enable, that inverts on every overflow. A system can wire this pin to its own reset, so that a missed service produces a reset pulse. When the channel's own reset is asserted, the pin level and its enable are held for three more clock cycles before they clear. This stands in for a hold of two and a half internal cycles, so that the reset pulse the pin produced stays long enough to be valid.

Only mode code 1010 runs the channel. Codes 8 and 11 to 15 are reserved. A control write that carries a reserved code leaves the stored mode unchanged. Any other non-1010 code is stored but keeps the channel idle.

Top module: `wdt_toggle_channel`

## Requirements
- R1: Synchronous reset clears the control word, the reload, compare and count registers, and both flags. The pin level and pin_drive keep their previous values for the first 3 clock edges of reset, then clear to 0 on the 4th and later edges.
- R2: Register address 0 is the control/status word. Bits [3:0] hold the mode, bit 4 enables, bit 5 selects the external tick, bit 6 selects reload-on-match, bit 7 sets the pin polarity, bit 8 is the compare interrupt enable, bit 9 is the overflow interrupt enable, bit 16 is the compare flag and bit 17 is the overflow flag. A write to address 0 that takes the channel from idle to running (enable 1, mode 1010) clears the count to 0, sets pin_out to bit 7 and sets pin_drive to 1.
- R3: After a start, the first timer tick loads the reload register (address 1) into the count. Each later tick adds 1. The count is readable at address 3 at any time without affecting it.
- R4: With bit 5 at 0, a tick occurs on every second clock edge, so 8 consecutive edges give exactly 4 ticks. With bit 5 at 1, a tick occurs on each clock edge where pre_tick is high, and on no other edge.
- R5: The compare flag is set on the tick that makes the count equal the compare register (address 2). irq_cmp is high while both the flag and bit 8 are 1.
- R6: On a tick while the count equals the compare value: if bit 6 is 1, the count loads the reload value; if bit 6 is 0, it keeps incrementing.
- R7: An incrementing tick from 0xFFFFFF wraps the count to 0, inverts pin_out and sets the overflow flag. irq_ovf is high while both the flag and bit 9 are 1.
- R8: Writing 1 to bit 16 or bit 17 at address 0 clears that flag. Writing 0 leaves it unchanged. A flag that is set and cleared in the same cycle stays set.
- R9: A write to the reload register while running loads the written value into the count on that same edge. This takes priority over a tick.
- R10: While the channel is not running, the count and pin_out do not change.
- R11: A control write whose mode code is 8, 11, 12, 13, 14 or 15 leaves the stored mode unchanged, and the other bits are still written. A stored mode other than 1010 keeps the channel idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_tick | input | 1 | External prescaler tick pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 ctrl/status, 1 reload, 2 compare, 3 count, read-only) |
| wr_data | input | 24 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 24 | Read data for rd_addr, combinational |
| pin_out | output | 1 | Toggle output level |
| pin_drive | output | 1 | Output enable of the toggle pin |
| irq_cmp | output | 1 | Compare interrupt request |
| irq_ovf | output | 1 | Overflow interrupt request |

## Verification
The hardest state to reach is an overflow, because the count must climb to 0xFFFFFF. The stimulus programs a reload value a few steps below all ones and drives external ticks one at a time, so the wrap happens after only four ticks. The other hard corner is the reset-hold window, which needs the pin driven high before reset begins. The bench starts the channel with the polarity bit set and only then asserts reset, so it can watch the held level edge by edge. A stretch of pseudo-random ticks and register writes, compared every clock against a behavioural model, adds simultaneous matches, clears and reloads.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int CNT_W   = 24;
    localparam int ADDR_W  = 2;
    localparam int MODE_W  = 4;
    localparam int HOLD_CYC = 3;

    localparam logic [MODE_W-1:0] MODE_TOGGLE = 4'b1010;

    localparam logic [ADDR_W-1:0] A_CTRL    = 2'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD  = 2'd1;
    localparam logic [ADDR_W-1:0] A_COMPARE = 2'd2;
    localparam logic [ADDR_W-1:0] A_COUNT   = 2'd3;

    localparam int CMP_FLAG_BIT = 16;
    localparam int OVF_FLAG_BIT = 17;
    localparam int CTRL_BITS    = 10;

    typedef struct packed {
        logic              ovf_ie;
        logic              cmp_ie;
        logic              invert;
        logic              reload_mode;
        logic              src_ext;
        logic              enable;
        logic [MODE_W-1:0] mode;
    } ctrl_t;

    function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
        return (m == 4'd8) || (m >= 4'd11);
    endfunction

    function automatic logic ctrl_runs(input ctrl_t c);
        return c.enable && (c.mode == MODE_TOGGLE);
    endfunction

endpackage

// File: rtl/wdt_tick_src.sv
module wdt_tick_src (
    input  logic clk,
    input  logic rst,
    input  logic src_ext,
    input  logic pre_tick,
    output logic tick
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (rst) half_q <= 1'b0;
        else     half_q <= ~half_q;
    end

    assign tick = src_ext ? pre_tick : half_q;
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
    parameter int CNT_W = wdt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  logic             tick,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] wr_value,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] compare_val,
    input  logic             reload_mode,
    output logic [CNT_W-1:0] cnt,
    output logic             load_now,
    output logic             cmp_evt,
    output logic             ovf_evt
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] nxt;
    logic             first_q;
    logic             step;

    assign load_now = first_q || (reload_mode && (cnt_q == compare_val));
    assign nxt      = load_now ? reload_val : cnt_q + 1'b1;
    assign step     = run && tick && !reload_wr;
    assign cmp_evt  = step && (nxt == compare_val);
    assign ovf_evt  = step && !load_now && (cnt_q == ALL_ONES);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
        end else if (start) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
        end else if (run && reload_wr) begin
            cnt_q   <= wr_value;
            first_q <= 1'b0;
        end else if (step) begin
            cnt_q   <= nxt;
            first_q <= 1'b0;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/wdt_pin_ctrl.sv
module wdt_pin_ctrl #(
    parameter int HOLD_CYC = wdt_pkg::HOLD_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic invert,
    input  logic ovf_evt,
    output logic pin,
    output logic drive
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] hold_q;
    logic          pin_q;
    logic          drv_q;

    // The pin keeps its level for HOLD_CYC reset edges. Three whole cycles
    // stand in for a hold of two and a half internal cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            if (hold_q != HW'(HOLD_CYC)) begin
                hold_q <= hold_q + 1'b1;
            end else begin
                pin_q <= 1'b0;
                drv_q <= 1'b0;
            end
        end else begin
            hold_q <= '0;
            if (start) begin
                pin_q <= invert;
                drv_q <= 1'b1;
            end else if (ovf_evt) begin
                pin_q <= ~pin_q;
            end
        end
    end

    assign pin   = pin_q;
    assign drive = drv_q;
endmodule

// File: rtl/wdt_toggle_channel.sv
module wdt_toggle_channel #(
    parameter int CNT_W    = wdt_pkg::CNT_W,
    parameter int HOLD_CYC = wdt_pkg::HOLD_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pre_tick,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             pin_out,
    output logic             pin_drive,
    output logic             irq_cmp,
    output logic             irq_ovf
);
    import wdt_pkg::*;

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_new;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] compare_q;
    logic             cmp_flag_q;
    logic             ovf_flag_q;

    logic             ctrl_wr;
    logic             reload_wr;
    logic             compare_wr;
    logic             running;
    logic             start;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             load_now;
    logic             cmp_evt;
    logic             ovf_evt;

    assign ctrl_wr    = wr_en && (wr_addr == A_CTRL);
    assign reload_wr  = wr_en && (wr_addr == A_RELOAD);
    assign compare_wr = wr_en && (wr_addr == A_COMPARE);
    assign running    = ctrl_runs(ctrl_q);

    always_comb begin
        ctrl_new = ctrl_t'(wr_data[CTRL_BITS-1:0]);
        if (mode_reserved(ctrl_new.mode)) ctrl_new.mode = ctrl_q.mode;
    end

    assign start = ctrl_wr && ctrl_runs(ctrl_new) && !running;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            reload_q  <= '0;
            compare_q <= '0;
        end else begin
            if (ctrl_wr)    ctrl_q    <= ctrl_new;
            if (reload_wr)  reload_q  <= wr_data;
            if (compare_wr) compare_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_flag_q <= 1'b0;
            ovf_flag_q <= 1'b0;
        end else begin
            if (cmp_evt)                              cmp_flag_q <= 1'b1;
            else if (ctrl_wr && wr_data[CMP_FLAG_BIT]) cmp_flag_q <= 1'b0;
            if (ovf_evt)                              ovf_flag_q <= 1'b1;
            else if (ctrl_wr && wr_data[OVF_FLAG_BIT]) ovf_flag_q <= 1'b0;
        end
    end

    wdt_tick_src u_tick (
        .clk      (clk),
        .rst      (rst),
        .src_ext  (ctrl_q.src_ext),
        .pre_tick (pre_tick),
        .tick     (tick)
    );

    wdt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst         (rst),
        .run         (running),
        .start       (start),
        .tick        (tick),
        .reload_wr   (reload_wr),
        .wr_value    (wr_data),
        .reload_val  (reload_q),
        .compare_val (compare_q),
        .reload_mode (ctrl_q.reload_mode),
        .cnt         (cnt),
        .load_now    (load_now),
        .cmp_evt     (cmp_evt),
        .ovf_evt     (ovf_evt)
    );

    wdt_pin_ctrl #(.HOLD_CYC(HOLD_CYC)) u_pin (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .invert  (ctrl_new.invert),
        .ovf_evt (ovf_evt),
        .pin     (pin_out),
        .drive   (pin_drive)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_CTRL: begin
                rd_data[CTRL_BITS-1:0] = ctrl_q;
                rd_data[CMP_FLAG_BIT]  = cmp_flag_q;
                rd_data[OVF_FLAG_BIT]  = ovf_flag_q;
            end
            A_RELOAD:  rd_data = reload_q;
            A_COMPARE: rd_data = compare_q;
            default:   rd_data = cnt;
        endcase
    end

    assign irq_cmp = cmp_flag_q && ctrl_q.cmp_ie;
    assign irq_ovf = ovf_flag_q && ctrl_q.ovf_ie;
endmodule

// File: rtl/wdt_toggle_chk.sv
module wdt_toggle_chk #(
    parameter int CNT_W = wdt_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             running,
    input logic             start,
    input logic             tick,
    input logic             reload_wr,
    input logic             compare_wr,
    input logic             load_now,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] compare,
    input logic             pin,
    input logic             drive,
    input logic             ovf_evt,
    input logic             cmp_flag,
    input logic             ctrl_wr,
    input logic             clr_cmp,
    input logic [3:0]       mode
);
    assert_start_drive_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (drive && cnt == '0));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (running && tick && !load_now && !reload_wr && !start)
        |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    assert_flag_match_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(cmp_flag) && !$past(compare_wr)) |-> (cnt == compare));

    assert_pin_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && pin != $past(pin)) |-> ($past(ovf_evt) || $past(start)));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(cmp_flag) |-> $past(ctrl_wr && clr_cmp));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> $stable(cnt));

    assert_mode_legal_R11: assert property (@(posedge clk) disable iff (rst)
        !wdt_pkg::mode_reserved(mode));
endmodule

bind wdt_toggle_channel wdt_toggle_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .running    (running),
    .start      (start),
    .tick       (tick),
    .reload_wr  (reload_wr),
    .compare_wr (compare_wr),
    .load_now   (load_now),
    .cnt        (cnt),
    .compare    (compare_q),
    .pin        (pin_out),
    .drive      (pin_drive),
    .ovf_evt    (ovf_evt),
    .cmp_flag   (cmp_flag_q),
    .ctrl_wr    (ctrl_wr),
    .clr_cmp    (wr_data[16]),
    .mode       (ctrl_q.mode)
);

// File: tb/wdt_toggle_channel_test.sv
`timescale 1ns/1ps
module wdt_toggle_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pre_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [23:0] wr_data = 24'd0;
    logic [1:0]  rd_addr = 2'd3;
    logic [23:0] rd_data;
    logic        pin_out, pin_drive, irq_cmp, irq_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    wdt_toggle_channel uut (
        .clk(clk), .rst(rst), .pre_tick(pre_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pin_out(pin_out), .pin_drive(pin_drive),
        .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    logic [9:0]  m_ctrl = '0;
    logic [23:0] m_rl = '0, m_cv = '0, m_cnt = '0;
    logic        m_first = 0, m_fc = 0, m_fo = 0, m_pin = 0, m_drv = 0, m_div = 0;
    logic        m_known = 0;
    int          m_hold = 0;

    function automatic logic [23:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {6'd0, m_fo, m_fc, 6'd0, m_ctrl};
            2'd1:    return m_rl;
            2'd2:    return m_cv;
            default: return m_cnt;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [9:0] nc;
        logic run, st, tk, ce, oe;
        if (rst) begin
            m_ctrl = '0; m_rl = '0; m_cv = '0; m_cnt = '0; m_first = 0;
            m_fc = 0; m_fo = 0; m_div = 0;
            if (m_hold < 3) m_hold++;
            else begin m_pin = 0; m_drv = 0; m_known = 1; end
        end else begin
            m_hold = 0;
            tk = m_ctrl[5] ? pre_tick : m_div;
            m_div = !m_div;
            run = m_ctrl[4] && (m_ctrl[3:0] == 4'hA);
            nc = wr_data[9:0];
            if (nc[3:0] == 4'd8 || nc[3:0] >= 4'd11) nc[3:0] = m_ctrl[3:0];
            st = wr_en && wr_addr == 0 && nc[4] && nc[3:0] == 4'hA && !run;
            ce = 0; oe = 0;
            if (st) begin
                m_cnt = 0; m_first = 1; m_pin = nc[7]; m_drv = 1;
            end else if (run && wr_en && wr_addr == 1) begin
                m_cnt = wr_data; m_first = 0;
            end else if (run && tk) begin
                if (m_first || (m_ctrl[6] && m_cnt == m_cv)) m_cnt = m_rl;
                else begin
                    if (m_cnt == 24'hFFFFFF) oe = 1;
                    m_cnt = m_cnt + 24'd1;
                end
                m_first = 0;
                if (m_cnt == m_cv) ce = 1;
            end
            if (oe) m_pin = !m_pin;
            if (ce) m_fc = 1; else if (wr_en && wr_addr == 0 && wr_data[16]) m_fc = 0;
            if (oe) m_fo = 1; else if (wr_en && wr_addr == 0 && wr_data[17]) m_fo = 0;
            if (wr_en && wr_addr == 0) m_ctrl = nc;
            if (wr_en && wr_addr == 1) m_rl = wr_data;
            if (wr_en && wr_addr == 2) m_cv = wr_data;
        end
    end

    always @(negedge clk) begin
        if (m_known) begin
            chk("R7 pin_out vs model", pin_out, m_pin);
            chk("R2 pin_drive vs model", pin_drive, m_drv);
            if (!rst) begin
                chk("R3 rd_data vs model", rd_data, exp_rd(rd_addr));
                chk("R5 irq_cmp vs model", irq_cmp, m_fc & m_ctrl[8]);
                chk("R7 irq_ovf vs model", irq_ovf, m_fo & m_ctrl[9]);
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0; wr_data = 0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; pre_tick = 1;
            @(posedge clk); #1; pre_tick = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic rd(input logic [1:0] a, output logic [23:0] v);
        rd_addr = a; #0.5; v = rd_data;
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [23:0] v;
        logic [15:0] lf;
        idle(6);
        rst = 0;
        idle(1);
        rd(0, v); chk("R1 ctrl after reset", v, 0);
        rd(3, v); chk("R1 count after reset", v, 0);
        chk("R1 pin after reset", {pin_drive, pin_out}, 0);

        // external ticks, polarity 1
        wr(1, 24'd100); wr(2, 24'hFFFF00);
        wr(0, 24'h0000BA);
        rd(3, v); chk("R2 count cleared on start", v, 0);
        chk("R2 pin takes polarity", {pin_drive, pin_out}, 2'b11);
        pulse(1); rd(3, v); chk("R3 first tick loads reload", v, 100);
        idle(5);  rd(3, v); chk("R4 no tick without pre_tick", v, 100);
        pulse(2); rd(3, v); chk("R3 later ticks increment", v, 102);

        // internal divided clock
        wr(0, 24'h00000A); wr(0, 24'h00001A);
        chk("R2 pin low polarity", {pin_drive, pin_out}, 2'b10);
        idle(8); rd(3, v); chk("R4 divided clock 4 ticks in 8", v, 103);

        // compare with reload
        wr(0, 24'h00000A); wr(1, 24'h20); wr(2, 24'h22);
        wr(0, 24'h00017A);
        pulse(3); rd(3, v); chk("R5 count at match", v, 24'h22);
        chk("R5 irq_cmp raised", irq_cmp, 1);
        rd(0, v); chk("R5 compare flag bit16", v[16], 1);
        pulse(1); rd(3, v); chk("R6 reload after match", v, 24'h20);
        wr(0, 24'h01017A);
        chk("R8 irq_cmp cleared by W1C", irq_cmp, 0);
        rd(0, v); chk("R8 flag bit16 cleared", v[16], 0);
        rd(3, v); chk("R8 running not restarted", v, 24'h20);
        wr(0, 24'h00013A);
        pulse(2); chk("R5 match again", irq_cmp, 1);
        pulse(1); rd(3, v); chk("R6 continues past match", v, 24'h23);

        // overflow
        wr(0, 24'h03000A); wr(1, 24'hFFFFFD); wr(2, 24'h000100);
        wr(0, 24'h00023A);
        chk("R2 pin low before overflow", pin_out, 0);
        pulse(4); rd(3, v); chk("R7 wrap to zero", v, 0);
        chk("R7 pin inverted", pin_out, 1);
        chk("R7 irq_ovf raised", irq_ovf, 1);
        pulse(1); rd(3, v); chk("R7 counts on from zero", v, 1);

        wr(1, 24'h000500);
        rd(3, v); chk("R9 reload write reloads count", v, 24'h500);

        wr(0, 24'h00022A);
        pulse(3); rd(3, v); chk("R10 disabled count frozen", v, 24'h500);
        chk("R10 disabled pin held", pin_out, 1);

        wr(0, 24'h00000C);
        rd(0, v); chk("R11 reserved mode ignored", v[9:0], 10'h00A);
        wr(0, 24'h000033);
        rd(0, v); chk("R11 other mode stored", v[9:0], 10'h033);
        pulse(3); rd(3, v); chk("R11 non-toggle mode idle", v, 24'h500);

        // pseudo-random stretch checked against the model
        wr(0, 24'h03000A);
        lf = 16'hACE1;
        for (int i = 0; i < 800; i++) begin
            @(posedge clk); #1;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            pre_tick = lf[0];
            wr_en = (lf[5:3] == 3'd0);
            wr_addr = lf[7:6];
            rd_addr = lf[9:8];
            case (lf[7:6])
                2'd0: wr_data = {6'd0, lf[9:8], 6'd0, lf[15:10], lf[2] ? 4'hA : lf[14:11]};
                2'd1: wr_data = {16'hFFFF, lf[15:8]};
                default: wr_data = {16'hFFFF, lf[12:5]};
            endcase
        end
        wr_en = 0;

        // reset hold of the pin
        wr(0, 24'h00000A); wr(0, 24'h0000BA);
        chk("R1 pin high before reset", pin_out, 1);
        rst = 1;
        for (int k = 1; k <= 4; k++) begin
            @(posedge clk); #1;
            chk($sformatf("R1 pin_out after reset edge %0d", k), pin_out, (k < 4) ? 1 : 0);
            chk($sformatf("R1 pin_drive after reset edge %0d", k), pin_drive, (k < 4) ? 1 : 0);
        end
        rst = 0;
        idle(1);
        rd(0, v); chk("R1 ctrl cleared", v, 0);
        finish_run();
    end
endmodule